// File: doc/BRIEF.md
# Debug Serial Command Port

This block is the target side of a slow serial link that an external debug controller uses to talk to a processor core. The controller drives a serial clock, a serial data line and a debug request line, and watches a single serial data-out line. Everything is sampled with the processor clock: the three inputs pass through a synchroniser, and the port acts on the serial-clock edges that it detects. For this to work, the serial clock may run at no more than one eighth of the processor clock.

A session starts when the controller raises the debug request while the core runs. The port asks the core to halt. Once the core reports debug mode, the port pulls data-out low for a short pulse and then waits for commands. A command is one byte. Its top bit selects read or write, and its low five bits select one of 32 debug registers. A read makes the port fetch the register and signal with a pulse; the 24-bit value is then shifted out. A write is signalled with a pulse, then the 24-bit word is shifted in and written, and a second pulse confirms the write.

If the controller loses its bit count, it raises and releases the debug request during debug mode. The port then signals with a pulse and returns to the start of a command.

Top module: `dbg_serial_port`

## Requirements
- R1: While reset is held and right after it, data-out is high and enter_req, reg_rd and reg_we are low.
- R2: A debug request raised while the core is not in debug mode sets enter_req until the core reports debug mode. On entry to debug mode, data-out gives one acknowledge pulse.
- R3: While core_dbg is low, serial input has no effect: no register strobe occurs and data-out stays high.
- R4: A command is 8 bits, sent most significant bit first and captured on falling serial-clock edges. Bit 7 set to 1 means read and 0 means write. Bits 4:0 are the register address and bits 6:5 are ignored.
- R5: After a read command, reg_rd is high for one cycle with the address, and then an acknowledge pulse follows. The 24-bit value read is then presented most significant bit first, with data-out changing after each rising serial-clock edge, for 24 serial clocks.
- R6: After a write command, an acknowledge pulse is given. The next 24 bits, most significant bit first on falling edges, are then written with one reg_we cycle carrying the address and data, and a second acknowledge pulse follows.
- R7: Every acknowledge pulse holds data-out low for exactly 4 processor clocks. Outside pulses and read data, data-out is high.
- R8: A debug request raised in debug mode gives an acknowledge pulse and discards any partly shifted command or data. After the request is released, the next bit starts a new command.
- R9: While the debug request is still held after an acknowledge, serial input is ignored.
- R10: If the core leaves debug mode in the middle of a transfer, the transfer is abandoned without a write. A later entry starts again with an entry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_sck_i | input | 1 | Serial clock from the debug controller (asynchronous) |
| dbg_sdi_i | input | 1 | Serial data in (asynchronous) |
| dbg_req_i | input | 1 | Debug request, active high (asynchronous) |
| dbg_sdo_o | output | 1 | Serial data out; low pulses acknowledge |
| core_dbg_i | input | 1 | Core is in debug mode |
| enter_req_o | output | 1 | Request to the core to enter debug mode |
| reg_addr_o | output | 5 | Debug register address |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 24 | Write data |
| reg_rdata_i | input | 24 | Read data, valid in the reg_rd cycle |

## Verification
A wrong bit count or a wrong state shows at the ports within one serial word. An acknowledge pulse is then missing, or comes one serial clock early or late. Otherwise a strobe carries the wrong address, or read data comes back shifted by one bit. Every transaction is therefore checked end to end: the pulse count and pulse width, the strobe count and address, and the data word. The resynchronisation and abort cases are followed by a normal read, so that state left behind turns up as a corrupted word within 32 serial clocks.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_ACK,
      ST_HOLD,
      ST_CMD,
      ST_FETCH,
      ST_RD_SHIFT,
      ST_WR_SHIFT,
      ST_COMMIT
   } port_state_e;

   localparam int unsigned IDX_SCK = 0;
   localparam int unsigned IDX_SDI = 1;
   localparam int unsigned IDX_REQ = 2;
   localparam int unsigned N_ASYNC = 3;

endpackage

// File: rtl/dbg_sync_chain.sv
module dbg_sync_chain #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dbg_sync_chain: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("dbg_sync_chain: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbg_edge_det.sv
module dbg_edge_det #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= level_i;
      end
   end

   for (genvar g = 0; g < W; g++) begin : g_bit
      assign rise_o[g] =  level_i[g] & ~prev_q[g];
      assign fall_o[g] = ~level_i[g] &  prev_q[g];
   end

endmodule

// File: rtl/dbg_ack_gen.sv
module dbg_ack_gen #(
   parameter int unsigned ACK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic busy_o,
   output logic last_o
);

   localparam int unsigned CW = $clog2(ACK_CYCLES + 1);
   localparam int unsigned RW = CW + 1;

   if (ACK_CYCLES < 2) begin : g_bad_len
      $error("dbg_ack_gen: ACK_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (abort_i) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= CW'(ACK_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign last_o = (cnt_q == CW'(1));

   // pulse-length checker
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (busy_o) begin
         run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   // R7
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) && !$past(abort_i) |-> run_q == RW'(ACK_CYCLES));

   // R7
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !abort_i |=> busy_o);

endmodule

// File: rtl/dbg_shifter.sv
module dbg_shifter #(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] q_o
);

   if (W < 2) begin : g_bad_width
      $error("dbg_shifter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (load_i) begin
         q_o <= load_val_i;
      end else if (clr_i) begin
         q_o <= '0;
      end else if (shift_i) begin
         q_o <= {q_o[W-2:0], bit_i};
      end
   end

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
   import dbg_port_pkg::*;
#(
   parameter int unsigned DATA_W      = 24,
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned ACK_CYCLES  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_sck_i,
   input  logic              dbg_sdi_i,
   input  logic              dbg_req_i,
   output logic              dbg_sdo_o,
   input  logic              core_dbg_i,
   output logic              enter_req_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              reg_rd_o,
   output logic              reg_we_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   input  logic [DATA_W-1:0] reg_rdata_i
);

   localparam int unsigned CNT_W     = $clog2(DATA_W);
   localparam int unsigned CMD_LAST  = CMD_W - 1;
   localparam int unsigned DATA_LAST = DATA_W - 1;
   localparam int unsigned RD_BIT    = CMD_W - 1;

   if (CMD_W <= ADDR_W) begin : g_bad_cmd
      $error("dbg_serial_port: command must hold address plus direction bit");
   end
   if (CMD_W > DATA_W) begin : g_bad_data
      $error("dbg_serial_port: command wider than data shifter");
   end

   // ---------------- input sampling ----------------
   logic [N_ASYNC-1:0] sync_v;
   logic [1:0]         rise_v;
   logic [1:0]         fall_v;

   dbg_sync_chain #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({dbg_req_i, dbg_sdi_i, dbg_sck_i}),
      .sync_o  (sync_v)
   );

   dbg_edge_det #(.W(2)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i ({sync_v[IDX_REQ], sync_v[IDX_SCK]}),
      .rise_o  (rise_v),
      .fall_o  (fall_v)
   );

   logic sck_rise, sck_fall, req_rise, req_fall, req_s, sdi_s;
   assign sck_rise = rise_v[0];
   assign sck_fall = fall_v[0];
   assign req_rise = rise_v[1];
   assign req_fall = fall_v[1];
   assign req_s    = sync_v[IDX_REQ];
   assign sdi_s    = sync_v[IDX_SDI];

   // ---------------- state ----------------
   port_state_e       state_q, state_d, after_q, after_d;
   logic [CNT_W-1:0]  cnt_q;
   logic [CMD_W-1:0]  cmd_q;
   logic              out_bit_q;
   logic              enter_q;

   logic              sh_clr, sh_load, sh_shift, sh_bit;
   logic              cnt_clr, cnt_inc, cmd_cap;
   logic [DATA_W-1:0] sh_q;
   logic [CMD_W-1:0]  cmd_next;
   logic              ack_start, ack_busy, ack_last;

   assign cmd_next = {sh_q[CMD_W-2:0], sdi_s};

   always_comb begin
      state_d  = state_q;
      after_d  = after_q;
      sh_clr   = 1'b0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      cnt_clr  = 1'b0;
      cnt_inc  = 1'b0;
      cmd_cap  = 1'b0;
      if (!core_dbg_i) begin
         state_d = ST_OFF;
      end else begin
         case (state_q)
            ST_OFF: begin
               state_d = ST_ACK;
               after_d = ST_HOLD;
            end
            ST_ACK: begin
               if (ack_last) state_d = after_q;
            end
            ST_HOLD: begin
               if (!req_s) begin
                  state_d = ST_CMD;
                  cnt_clr = 1'b1;
                  sh_clr  = 1'b1;
               end
            end
            default: begin
               if (req_rise) begin
                  state_d = ST_ACK;
                  after_d = ST_HOLD;
                  cnt_clr = 1'b1;
                  sh_clr  = 1'b1;
               end else begin
                  case (state_q)
                     ST_CMD: begin
                        if (sck_fall) begin
                           if (cnt_q == CNT_W'(CMD_LAST)) begin
                              cmd_cap = 1'b1;
                              cnt_clr = 1'b1;
                              if (cmd_next[RD_BIT]) begin
                                 state_d = ST_FETCH;
                              end else begin
                                 state_d = ST_ACK;
                                 after_d = ST_WR_SHIFT;
                                 sh_clr  = 1'b1;
                              end
                           end else begin
                              sh_shift = 1'b1;
                              cnt_inc  = 1'b1;
                           end
                        end
                     end
                     ST_FETCH: begin
                        sh_load = 1'b1;
                        cnt_clr = 1'b1;
                        state_d = ST_ACK;
                        after_d = ST_RD_SHIFT;
                     end
                     ST_RD_SHIFT: begin
                        if (sck_rise) sh_shift = 1'b1;
                        if (sck_fall) begin
                           if (cnt_q == CNT_W'(DATA_LAST)) begin
                              state_d = ST_CMD;
                              cnt_clr = 1'b1;
                              sh_clr  = 1'b1;
                           end else begin
                              cnt_inc = 1'b1;
                           end
                        end
                     end
                     ST_WR_SHIFT: begin
                        if (sck_fall) begin
                           sh_shift = 1'b1;
                           if (cnt_q == CNT_W'(DATA_LAST)) begin
                              state_d = ST_COMMIT;
                              cnt_clr = 1'b1;
                           end else begin
                              cnt_inc = 1'b1;
                           end
                        end
                     end
                     ST_COMMIT: begin
                        state_d = ST_ACK;
                        after_d = ST_CMD;
                        sh_clr  = 1'b1;
                     end
                     default: state_d = ST_OFF;
                  endcase
               end
            end
         endcase
      end
   end

   assign ack_start = (state_d == ST_ACK) && (state_q != ST_ACK);
   assign sh_bit    = (state_q == ST_RD_SHIFT) ? 1'b0 : sdi_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_OFF;
         after_q   <= ST_HOLD;
         cnt_q     <= '0;
         cmd_q     <= '0;
         out_bit_q <= 1'b1;
         enter_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         after_q <= after_d;
         if (cnt_clr) begin
            cnt_q <= '0;
         end else if (cnt_inc) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (cmd_cap) cmd_q <= cmd_next;
         if (state_q != ST_RD_SHIFT) begin
            out_bit_q <= 1'b1;
         end else if (sck_rise) begin
            out_bit_q <= sh_q[DATA_W-1];
         end
         if (core_dbg_i || req_fall) begin
            enter_q <= 1'b0;
         end else if (req_rise) begin
            enter_q <= 1'b1;
         end
      end
   end

   // ---------------- datapath ----------------
   dbg_shifter #(.W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (sh_clr),
      .load_i     (sh_load),
      .load_val_i (reg_rdata_i),
      .shift_i    (sh_shift),
      .bit_i      (sh_bit),
      .q_o        (sh_q)
   );

   dbg_ack_gen #(.ACK_CYCLES(ACK_CYCLES)) u_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (ack_start),
      .abort_i (!core_dbg_i),
      .busy_o  (ack_busy),
      .last_o  (ack_last)
   );

   assign dbg_sdo_o   = ack_busy ? 1'b0 :
                        ((state_q == ST_RD_SHIFT) ? out_bit_q : 1'b1);
   assign enter_req_o = enter_q;
   assign reg_addr_o  = cmd_q[ADDR_W-1:0];
   assign reg_rd_o    = (state_q == ST_FETCH);
   assign reg_we_o    = (state_q == ST_COMMIT);
   assign reg_wdata_o = sh_q;

   // ---------------- assertions ----------------
   // R3
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_dbg_i |=> !reg_we_o && !reg_rd_o && dbg_sdo_o);

   // R2
   enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_dbg_i |=> !enter_req_o);

   // R2
   entry_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_dbg_i) |=> !dbg_sdo_o);

   // R5
   rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o && core_dbg_i |=> !dbg_sdo_o && !reg_rd_o);

   // R6
   wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we_o && core_dbg_i |=> !dbg_sdo_o && !reg_we_o);

   // R8
   resync_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CMD) && req_rise && core_dbg_i |=> !dbg_sdo_o);

   // R1
   always_comb begin
      if (!rst_n) begin
         reset_quiet_chk: assert (dbg_sdo_o && !reg_we_o && !reg_rd_o);
      end
   end

endmodule

// File: tb/dbg_serial_port_test.sv
module dbg_serial_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, sdi = 1'b0, dreq = 1'b0, core_dbg = 1'b0;
   logic        sdo, enter_req, reg_rd, reg_we;
   logic [4:0]  reg_addr;
   logic [23:0] reg_wdata, reg_rdata;

   always #10 clk = ~clk;

   dbg_serial_port uut (
      .clk(clk), .rst_n(rst_n), .dbg_sck_i(sck), .dbg_sdi_i(sdi),
      .dbg_req_i(dreq), .dbg_sdo_o(sdo), .core_dbg_i(core_dbg),
      .enter_req_o(enter_req), .reg_addr_o(reg_addr), .reg_rd_o(reg_rd),
      .reg_we_o(reg_we), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
   );

   // register-file model
   logic [23:0] mem [32];
   int we_cnt = 0, rd_cnt = 0;
   logic [4:0] last_raddr = '0;
   assign reg_rdata = mem[reg_addr];

   initial for (int i = 0; i < 32; i++) mem[i] = '0;

   always @(posedge clk) begin
      if (rst_n && reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (rst_n && reg_rd) begin
         rd_cnt <= rd_cnt + 1;
         last_raddr <= reg_addr;
      end
   end

   // low-pulse monitor on data-out
   int low_run = 0, pulse_cnt = 0, last_len = 0;
   always @(negedge clk) begin
      if (!sdo) begin
         low_run = low_run + 1;
      end else if (low_run != 0) begin
         pulse_cnt = pulse_cnt + 1;
         last_len  = low_run;
         low_run   = 0;
      end
   end

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one serial clock: data set with the rise, sampled by the port on the fall
   bit all_high;
   task automatic sbit(input logic b, output logic o);
      @(negedge clk);
      sdi = b;
      sck = 1'b1;
      wait_clks(8);
      o = sdo;
      if (!sdo) all_high = 0;
      sck = 1'b0;
      wait_clks(8);
   endtask

   task automatic send_cmd(input bit rd, input logic [4:0] a);
      logic [7:0] c;
      logic o;
      c = {rd, a[0], a[0], a};
      for (int i = 7; i >= 0; i--) sbit(c[i], o);
   endtask

   task automatic wait_pulses(input int target, input string req);
      int t;
      t = 0;
      while (pulse_cnt < target && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk(pulse_cnt >= target, req, "ack pulse seen", pulse_cnt, target);
      chk(last_len == 4, "R7", "ack pulse width", last_len, 4);
   endtask

   task automatic do_write(input logic [4:0] a, input logic [23:0] d, input string tag);
      int p0, w0;
      logic o;
      p0 = pulse_cnt; w0 = we_cnt;
      all_high = 1;
      send_cmd(1'b0, a);
      chk(all_high, "R7", "sdo high during command", 0, 1);
      wait_pulses(p0 + 1, "R6");
      for (int i = 23; i >= 0; i--) sbit(d[i], o);
      wait_pulses(p0 + 2, "R6");
      chk(we_cnt == w0 + 1, "R6", {tag, " write strobes"}, we_cnt - w0, 1);
      chk(mem[a] == d, "R6", {tag, " written word"}, mem[a], d);
   endtask

   task automatic do_read(input logic [4:0] a, input logic [23:0] exp, input string tag);
      int p0, r0;
      logic o;
      logic [23:0] got;
      p0 = pulse_cnt; r0 = rd_cnt;
      all_high = 1;
      send_cmd(1'b1, a);
      chk(all_high, "R7", "sdo high during command", 0, 1);
      wait_pulses(p0 + 1, "R5");
      chk(rd_cnt == r0 + 1, "R5", {tag, " read strobes"}, rd_cnt - r0, 1);
      chk(last_raddr == a, "R4", {tag, " read address"}, last_raddr, a);
      for (int i = 23; i >= 0; i--) begin
         sbit(1'b0, o);
         got[i] = o;
      end
      chk(got == exp, "R5", {tag, " read word"}, got, exp);
   endtask

   // vector table: [29] read, [28:24] address, [23:0] data / expected
   localparam logic [29:0] VEC [8] = '{
      {1'b0, 5'd3,  24'hA5A5A5},
      {1'b0, 5'd31, 24'hFFFFFF},
      {1'b0, 5'd0,  24'h000001},
      {1'b1, 5'd3,  24'hA5A5A5},
      {1'b0, 5'd16, 24'h800000},
      {1'b1, 5'd31, 24'hFFFFFF},
      {1'b1, 5'd0,  24'h000001},
      {1'b1, 5'd16, 24'h800000}
   };

   initial begin : main
      int p0, w0, r0;
      logic o;
      // R1 reset state
      wait_clks(3);
      chk(sdo === 1'b1, "R1", "sdo in reset", sdo, 1);
      chk(!enter_req && !reg_rd && !reg_we, "R1", "strobes in reset",
          {enter_req, reg_rd, reg_we}, 0);
      rst_n = 1'b1;
      wait_clks(4);
      chk(sdo === 1'b1, "R1", "sdo after reset", sdo, 1);

      // R3 input ignored outside debug mode
      p0 = pulse_cnt; w0 = we_cnt; r0 = rd_cnt;
      all_high = 1;
      send_cmd(1'b1, 5'd9);
      for (int i = 0; i < 24; i++) sbit(1'b1, o);
      chk(all_high && pulse_cnt == p0, "R3", "sdo quiet when off", pulse_cnt - p0, 0);
      chk(we_cnt == w0 && rd_cnt == r0, "R3", "no strobes when off",
          we_cnt - w0 + rd_cnt - r0, 0);

      // R2 entry handshake
      @(negedge clk); dreq = 1'b1;
      wait_clks(6);
      chk(enter_req === 1'b1, "R2", "enter request raised", enter_req, 1);
      p0 = pulse_cnt;
      core_dbg = 1'b1;
      wait_clks(2);
      chk(enter_req === 1'b0, "R2", "enter request dropped", enter_req, 0);
      wait_pulses(p0 + 1, "R2");

      // R9 bits ignored while request still held
      r0 = rd_cnt; w0 = we_cnt;
      send_cmd(1'b1, 5'd3);
      wait_clks(20);
      chk(pulse_cnt == p0 + 1 && rd_cnt == r0, "R9", "held request ignores bits",
          pulse_cnt - p0, 1);
      @(negedge clk); dreq = 1'b0;
      wait_clks(8);

      // R4 R5 R6 table walk
      for (int i = 0; i < 8; i++) begin
         if (VEC[i][29]) do_read(VEC[i][28:24], VEC[i][23:0], $sformatf("vec%0d", i));
         else            do_write(VEC[i][28:24], VEC[i][23:0], $sformatf("vec%0d", i));
      end

      // R8 resync after a partial command
      p0 = pulse_cnt;
      sbit(1'b1, o); sbit(1'b1, o); sbit(1'b0, o);
      @(negedge clk); dreq = 1'b1;
      wait_pulses(p0 + 1, "R8");
      @(negedge clk); dreq = 1'b0;
      wait_clks(8);
      do_read(5'd3, 24'hA5A5A5, "R8 after resync");

      // R10 leave debug mode mid-write
      p0 = pulse_cnt; w0 = we_cnt;
      send_cmd(1'b0, 5'd7);
      wait_pulses(p0 + 1, "R6");
      for (int i = 0; i < 10; i++) sbit(1'b1, o);
      @(negedge clk); core_dbg = 1'b0;
      all_high = 1;
      for (int i = 0; i < 14; i++) sbit(1'b1, o);
      wait_clks(10);
      chk(all_high && we_cnt == w0, "R10", "abandoned write", we_cnt - w0, 0);
      p0 = pulse_cnt;
      @(negedge clk); core_dbg = 1'b1;
      wait_pulses(p0 + 1, "R10");
      wait_clks(8);
      do_read(5'd7, 24'h000000, "R10 after re-entry");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule